// File: doc/BRIEF.md
# Profile-Switched Phase-Coherent Oscillator Bank

This block is a bank of complex numerically controlled oscillators that share one sample clock. Each oscillator owns a small profile store. A profile holds a frequency word, an unsigned amplitude and a phase offset. A host writes the profiles through a narrow word-serial port. A trigger port then names one profile per oscillator, and every oscillator moves to its named profile on the same output sample.

The phase of every oscillator is absolute. It is the frequency word times the number of samples since reset, plus the offset. Switching between profiles therefore never disturbs the phase a profile would have had if it had run without a break. Each oscillator's cosine and sine are scaled by the profile amplitude. The results of all oscillators are added with wrapping arithmetic into one signed I/Q sample per clock.

Top module: `phase_osc_bank`

## Requirements
- R1: While `rst` is high and after it is released, `sum_i` and `sum_q` read 0. Every oscillator selects profile 0, and every profile holds frequency 0, amplitude 0 and offset 0.
- R2: A write with `cfg_addr_sel`=1 sets the write target. The oscillator index is taken from `cfg_wdata` bit 6 upward, and the profile index from bit 1 upward (5 bits). The data writes that follow (`cfg_addr_sel`=0) alternate between the 32-bit frequency word (first) and a word holding the amplitude in [15:0] and the phase offset in [31:16] (second).
- R3: The output registered on the n-th rising edge with `rst` low (n counted from 0) uses the phase `ftw*n + (offset<<16)` mod 2^32 of each oscillator's active profile.
- R4: The phase of a profile does not depend on earlier profile history. Switching away and back gives the same samples as if the profile had stayed active.
- R5: When `trig_valid` is high at an edge, every oscillator g adopts profile `trig_prof[5g+4:5g]`. The output registered on the next edge is the first one to use the new profiles, for all oscillators together.
- R6: Phase bits [31:22] form a 10-bit angle k. The quarter table is T[j] = round(32767*sin(2*pi*(j+0.5)/1024)) for j = 0..255. sin(k) is T[k[7:0]] when k[8]=0 and T[255-k[7:0]] when k[8]=1, and it is negated when k[9]=1. The Q part uses sin(k), and the I part uses sin(k+256).
- R7: Each oscillator output is bits [31:16] of the two's-complement product of the signed 16-bit wave value and the unsigned 16-bit amplitude.
- R8: `sum_i` and `sum_q` are the 16-bit wrapping sums of all oscillator I and Q outputs, with no saturation.
- R9: A data write to the active profile of an oscillator is used by the output registered on the edge after the write edge.
- R10: Without `trig_valid`, the profile selection of every oscillator stays unchanged, whatever is written to the profile store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Profile port write strobe |
| cfg_addr_sel | input | 1 | 1: write is a target word, 0: write is a data word |
| cfg_wdata | input | 32 | Profile port write word |
| trig_valid | input | 1 | Pulse trigger strobe |
| trig_prof | input | N_OSC*5 | Profile index per oscillator, oscillator g at [5g+4:5g] |
| sum_i | output | 16 | Summed in-phase sample |
| sum_q | output | 16 | Summed quadrature sample |

## Verification
The assertions take for granted that reset is applied from the first clock. They also assume the strobes `trig_valid` and `cfg_we` are never unknown, and that `N_OSC` is a power of two, so that any oscillator field in a target word names a real oscillator. The stimulus drives every input to a known value from time zero, holds reset for several cycles, and only ever names oscillators 0 to 3 and profiles below 32. Under those conditions the bench scoreboards every output sample against a model driven only by the sample count and the profiles it has written.

// File: rtl/phase_osc_bank.sv
module phase_osc_bank #(
  parameter int N_OSC  = 4,
  parameter int N_PROF = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      cfg_addr_sel,
  input  logic [31:0]               cfg_wdata,
  input  logic                      trig_valid,
  input  logic [N_OSC*5-1:0]        trig_prof,
  output logic [15:0]               sum_i,
  output logic [15:0]               sum_q
);
  localparam int PW    = 5;
  localparam int OW    = (N_OSC > 1) ? $clog2(N_OSC) : 1;
  localparam int DEPTH = N_OSC * N_PROF;
  localparam int AW    = OW + PW;
  localparam real TWO_PI = 6.283185307179586;

  logic [31:0]   ftw_mem [DEPTH];
  logic [31:0]   ap_mem  [DEPTH];
  logic [15:0]   qtab    [256];
  logic [31:0]   tcnt;
  logic [AW-1:0] wptr;
  logic          second;
  logic [PW-1:0] sel [N_OSC];
  logic [15:0]   osc_i [N_OSC];
  logic [15:0]   osc_q [N_OSC];
  logic [N_OSC-1:0] amp_zero;
  logic [15:0]   acc_i, acc_q;

  initial begin
    for (int j = 0; j < 256; j++)
      qtab[j] = 16'($rtoi($floor(32767.0 * $sin(TWO_PI * (real'(j) + 0.5) / 1024.0) + 0.5)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt   <= '0;
      wptr   <= '0;
      second <= 1'b0;
      for (int a = 0; a < DEPTH; a++) begin
        ftw_mem[a] <= '0;
        ap_mem[a]  <= '0;
      end
    end else begin
      tcnt <= tcnt + 32'd1;
      if (cfg_we) begin
        if (cfg_addr_sel) begin
          wptr   <= {cfg_wdata[6 +: OW], cfg_wdata[1 +: PW]};
          second <= 1'b0;
        end else begin
          if (second) ap_mem[wptr]  <= cfg_wdata;
          else        ftw_mem[wptr] <= cfg_wdata;
          second <= ~second;
        end
      end
    end
  end

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    logic [AW-1:0] ra;
    logic [31:0]   ftw, ap, ph;
    logic [9:0]    ks, kc;
    logic [15:0]   ms, mc, sv, cv;
    logic [32:0]   pi_w, pq_w;

    always_ff @(posedge clk) begin
      if (rst)             sel[g] <= '0;
      else if (trig_valid) sel[g] <= trig_prof[g*PW +: PW];
    end

    assign ra   = {OW'(g), sel[g]};
    assign ftw  = ftw_mem[ra];
    assign ap   = ap_mem[ra];
    assign ph   = ftw * tcnt + {ap[31:16], 16'h0000};
    assign ks   = ph[31:22];
    assign kc   = ks + 10'd256;
    assign ms   = ks[8] ? qtab[~ks[7:0]] : qtab[ks[7:0]];
    assign mc   = kc[8] ? qtab[~kc[7:0]] : qtab[kc[7:0]];
    assign sv   = ks[9] ? 16'd0 - ms : ms;
    assign cv   = kc[9] ? 16'd0 - mc : mc;
    assign pi_w = {{17{cv[15]}}, cv} * {17'd0, ap[15:0]};
    assign pq_w = {{17{sv[15]}}, sv} * {17'd0, ap[15:0]};
    assign osc_i[g]    = pi_w[31:16];
    assign osc_q[g]    = pq_w[31:16];
    assign amp_zero[g] = (ap[15:0] == 16'd0);

    // R5
    trig_take_chk: assert property (@(posedge clk) disable iff (rst)
      trig_valid |=> sel[g] == $past(trig_prof[g*PW +: PW]));
    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !trig_valid |=> $stable(sel[g]));
  end

  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < N_OSC; k++) begin
      acc_i = acc_i + osc_i[k];
      acc_q = acc_q + osc_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_i <= '0;
      sum_q <= '0;
    end else begin
      sum_i <= acc_i;
      sum_q <= acc_q;
    end
  end

  // R3
  time_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tcnt == $past(tcnt) + 32'd1);
  // R7
  silent_chk: assert property (@(posedge clk) disable iff (rst)
    (&amp_zero) |=> (sum_i == 16'd0 && sum_q == 16'd0));
  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (sum_i == 16'd0 && sum_q == 16'd0));
endmodule

// File: tb/sim_phase_osc_bank.sv
module sim_phase_osc_bank;
  localparam int N = 4;
  localparam int NP = 32;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_addr_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic trig_valid = 1'b0;
  logic [N*5-1:0] trig_prof = '0;
  logic [15:0] sum_i, sum_q;

  int tests = 0, fails = 0;
  string tag = "R1";

  phase_osc_bank #(.N_OSC(N), .N_PROF(NP)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr_sel(cfg_addr_sel),
    .cfg_wdata(cfg_wdata), .trig_valid(trig_valid), .trig_prof(trig_prof),
    .sum_i(sum_i), .sum_q(sum_q));

  always #10 clk = ~clk;

  typedef struct { string t; logic [15:0] ei; logic [15:0] eq; } item_t;
  item_t sb[$];

  int tab [256];
  logic [31:0] m_ftw [N*NP];
  logic [31:0] m_ap  [N*NP];
  int m_sel [N];
  logic [31:0] m_t;
  int m_ptr;
  bit m_second;

  initial begin
    for (int j = 0; j < 256; j++)
      tab[j] = $rtoi($floor(32767.0 * $sin(TWO_PI * (real'(j) + 0.5) / 1024.0) + 0.5));
    for (int a = 0; a < N*NP; a++) begin m_ftw[a] = '0; m_ap[a] = '0; end
    for (int g = 0; g < N; g++) m_sel[g] = 0;
    m_t = '0; m_ptr = 0; m_second = 0;
  end

  function automatic int wave(logic [9:0] k);
    int m;
    m = k[8] ? tab[255 - int'(k[7:0])] : tab[int'(k[7:0])];
    return k[9] ? -m : m;
  endfunction

  function automatic logic [15:0] scale(int w, logic [15:0] amp);
    longint p;
    p = longint'(w) * longint'(amp);
    p = p >>> 16;
    return p[15:0];
  endfunction

  // model: expected output from pre-edge state, then apply inputs
  always @(posedge clk) begin
    if (!rst) begin
      item_t it;
      logic [15:0] si, sq;
      si = '0; sq = '0;
      for (int g = 0; g < N; g++) begin
        int a;
        logic [31:0] ph;
        a = g*NP + m_sel[g];
        ph = m_ftw[a] * m_t + {m_ap[a][31:16], 16'h0000};
        si = si + scale(wave(ph[31:22] + 10'd256), m_ap[a][15:0]);
        sq = sq + scale(wave(ph[31:22]), m_ap[a][15:0]);
      end
      it.t = tag; it.ei = si; it.eq = sq;
      sb.push_back(it);
      m_t = m_t + 1;
      if (cfg_we) begin
        if (cfg_addr_sel) begin
          m_ptr = int'(cfg_wdata[7:6]) * NP + int'(cfg_wdata[5:1]);
          m_second = 0;
        end else begin
          if (m_second) m_ap[m_ptr] = cfg_wdata;
          else          m_ftw[m_ptr] = cfg_wdata;
          m_second = !m_second;
        end
      end
      if (trig_valid)
        for (int g = 0; g < N; g++) m_sel[g] = int'(trig_prof[g*5 +: 5]);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      tests++;
      if (sum_i !== it.ei || sum_q !== it.eq) begin
        fails++;
        $display("FAIL %s t=%0d: got i=%h q=%h expected i=%h q=%h",
                 it.t, m_t, sum_i, sum_q, it.ei, it.eq);
      end
    end
  end

  task automatic cfg_write(input logic sel_addr, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr_sel = sel_addr; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr_sel = 1'b0; cfg_wdata = '0;
  endtask

  task automatic load_prof(input int o, input int p, input logic [31:0] ftw,
                           input logic [15:0] amp, input logic [15:0] off);
    cfg_write(1'b1, 32'((o << 6) | (p << 1)));
    cfg_write(1'b0, ftw);
    cfg_write(1'b0, {off, amp});
  endtask

  task automatic trigger(input int p0, input int p1, input int p2, input int p3);
    trig_valid = 1'b1;
    trig_prof = {5'(p3), 5'(p2), 5'(p1), 5'(p0)};
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (sum_i !== 16'd0 || sum_q !== 16'd0) begin
      fails++;
      $display("FAIL R1 reset: got i=%h q=%h expected i=0000 q=0000", sum_i, sum_q);
    end
    rst = 1'b0;
    tag = "R1"; idle(5);

    tag = "R2";
    load_prof(0, 1, 32'h0123_4567, 16'h8000, 16'h1000);
    load_prof(1, 1, 32'hF000_0000, 16'hFFFF, 16'h0000);
    load_prof(3, 31, 32'h0800_0000, 16'h4000, 16'hC000);
    load_prof(0, 2, 32'h0300_0000, 16'h7000, 16'h8000);
    idle(3);

    tag = "R5"; trigger(1, 1, 0, 31); idle(20);
    tag = "R4"; trigger(2, 1, 0, 31); idle(7);
    trigger(1, 1, 0, 31); idle(15);
    trigger(0, 1, 0, 0); idle(5);
    trigger(1, 1, 0, 31); idle(10);

    tag = "R6";
    load_prof(0, 4, 32'h0, 16'h8000, 16'h0000);
    load_prof(0, 5, 32'h0, 16'h8000, 16'h4000);
    load_prof(0, 6, 32'h0, 16'h8000, 16'h8000);
    load_prof(0, 7, 32'h0, 16'h8000, 16'hC000);
    for (int p = 4; p < 8; p++) begin trigger(p, 0, 0, 0); idle(3); end

    tag = "R7";
    load_prof(1, 8, 32'h0, 16'h0001, 16'h2000);
    load_prof(2, 8, 32'h0, 16'h1234, 16'hA000);
    trigger(0, 8, 8, 0); idle(4);

    tag = "R8";
    for (int g = 0; g < N; g++) load_prof(g, 3, 32'h0, 16'hFFFF, 16'h0000);
    trigger(3, 3, 3, 3); idle(4);
    load_prof(0, 9, 32'h0, 16'hFFFF, 16'hC000);
    load_prof(1, 9, 32'h0, 16'hFFFF, 16'hC000);
    trigger(9, 9, 3, 3); idle(4);

    tag = "R9"; trigger(3, 3, 3, 3); idle(2);
    load_prof(0, 3, 32'h0400_0000, 16'h3000, 16'h2000); idle(4);
    cfg_write(1'b0, 32'h0010_0000); idle(3);

    tag = "R10";
    load_prof(1, 3, 32'h0200_0000, 16'h5000, 16'h0000);
    idle(50);

    tag = "R3"; trigger(1, 1, 2, 31); idle(1200);
    tag = "R4"; trigger(2, 1, 2, 31); idle(13);
    trigger(1, 1, 2, 31); idle(40);

    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule